// File: doc/BRIEF.md
# Read-after-write interlock for a five-stage in-order pipeline

This block decides, every cycle, whether the instruction now in the decode stage has to wait because an older instruction still in the pipeline has not yet written a register that it reads. It looks at the one or two source register numbers of the decoding instruction. It compares them against the destination numbers and write enables carried by the three pipeline registers that follow decode: decode-to-execute, execute-to-memory and memory-to-writeback. When a wait is needed, it holds the program counter and the fetch/decode register. It also replaces the control bundle entering the decode-to-execute register with all zeros, so the slot inserted there writes nothing and touches no memory.

A run-time mode input selects between two pipeline builds. When no bypass network exists, any pending writer of a source forces a wait. When operands can be bypassed, only a load in the execute stage that feeds the next instruction forces a one-cycle wait. A parameter masks the writeback-stage comparison for register files that write in the first half of a cycle and read in the second. The decision is purely combinational and is valid in the same cycle as the decode-stage fields.

Top module: `raw_interlock`

## Requirements
- R1: With `fwd_en` low, `stall` is high whenever a used source equals a nonzero `ex_rd` whose `ex_wen` is set.
- R2: With `fwd_en` low, `stall` is high whenever a used source equals a nonzero `mem_rd` whose `mem_wen` is set.
- R3: With `fwd_en` low, a used source equal to a nonzero `wb_rd` with `wb_wen` set raises `stall` when `WB_RF_BYPASS` is 0. It has no effect when `WB_RF_BYPASS` is 1.
- R4: Register number 0 never produces a dependence, whatever the stage fields hold.
- R5: A stage whose write-enable bit is clear never produces a dependence.
- R6: A source whose use bit (`id_use_rs1` or `id_use_rs2`) is clear is never compared.
- R7: With `fwd_en` high, `stall` is high only when `ex_is_load` and `ex_wen` are set and a used source equals a nonzero `ex_rd`. Matches in the execute-to-memory and memory-to-writeback stages, and matches on non-load writers, are ignored.
- R8: `pc_we` and `ifid_we` are both the inverse of `stall`: both are 0 in a stall cycle and 1 otherwise.
- R9: In a stall cycle `idex_ctrl` is all zeros. Otherwise it equals `id_ctrl` bit for bit.
- R10: Both source fields are checked in the same way, so a dependence through the second source alone, such as an address base register, stalls exactly as one through the first source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | 1 when operand bypassing is present (load-use only), 0 for full interlock |
| id_rs1 | input | REG_AW | First source register number of the decoding instruction |
| id_use_rs1 | input | 1 | Decoding instruction reads its first source |
| id_rs2 | input | REG_AW | Second source register number of the decoding instruction |
| id_use_rs2 | input | 1 | Decoding instruction reads its second source |
| id_ctrl | input | CTRL_W | Execute/memory/writeback control bundle produced by decode |
| ex_rd | input | REG_AW | Destination held in decode-to-execute register |
| ex_wen | input | 1 | Register write enable held in decode-to-execute register |
| ex_is_load | input | 1 | Instruction in decode-to-execute register is a load |
| mem_rd | input | REG_AW | Destination held in execute-to-memory register |
| mem_wen | input | 1 | Register write enable held in execute-to-memory register |
| wb_rd | input | REG_AW | Destination held in memory-to-writeback register |
| wb_wen | input | 1 | Register write enable held in memory-to-writeback register |
| stall | output | 1 | Dependence detected this cycle |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_ctrl | output | CTRL_W | Control bundle to load into decode-to-execute register |

## Verification
The hardest case to reach is one where several stages name the same register while only some of them may count: for example, a non-load writer in execute, a load-free match further down with the mode bit high, and a zero destination in another stage. Directed tests place a single writer at a time. A sweep over register numbers 0 to 2 then covers every combination of both sources, both use bits, all three stage destinations, their enables, the load flag and the mode. That drives such overlapping and register-zero cases into every stage at once, on a masked and an unmasked instance side by side.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   localparam int NUM_SRC = 2;
   localparam int NUM_STG = 3;

   typedef enum logic [1:0] {
      STG_EX  = 2'd0,
      STG_MEM = 2'd1,
      STG_WB  = 2'd2
   } stage_e;
endpackage

// File: rtl/ilk_cmp.sv
module ilk_cmp #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic          src_used,
   input  logic [AW-1:0] dst,
   input  logic          dst_wen,
   output logic          hit
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   always_comb begin
      hit = src_used && dst_wen && (dst != ZERO_REG) && (dst == src);
   end
endmodule

// File: rtl/ilk_policy.sv
module ilk_policy
   import ilk_pkg::*;
#(
   parameter bit WB_RF_BYPASS = 1'b0
) (
   input  logic                              fwd_en,
   input  logic                              ex_is_load,
   input  logic [NUM_STG-1:0][NUM_SRC-1:0]   hit,
   output logic                              stall
);
   logic ex_any, mem_any, wb_any, full_ilk, load_use;

   always_comb begin
      ex_any  = |hit[STG_EX];
      mem_any = |hit[STG_MEM];
   end

   generate
      if (WB_RF_BYPASS) begin : g_wb_masked
         assign wb_any = 1'b0;
         logic unused_wb;
         assign unused_wb = |hit[STG_WB];
      end else begin : g_wb_live
         assign wb_any = |hit[STG_WB];
      end
   endgenerate

   always_comb begin
      full_ilk = ex_any | mem_any | wb_any;
      load_use = ex_any & ex_is_load;
      stall    = fwd_en ? load_use : full_ilk;
   end
endmodule

// File: rtl/ilk_bubble.sv
module ilk_bubble #(
   parameter int CW = 8
) (
   input  logic          stall,
   input  logic [CW-1:0] ctrl_in,
   output logic [CW-1:0] ctrl_out,
   output logic          pc_we,
   output logic          ifid_we
);
   always_comb begin
      ctrl_out = stall ? '0 : ctrl_in;
      pc_we    = ~stall;
      ifid_we  = ~stall;
   end
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
   import ilk_pkg::*;
#(
   parameter int REG_AW       = 5,
   parameter int CTRL_W       = 8,
   parameter bit WB_RF_BYPASS = 1'b0
) (
   input  logic              fwd_en,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic              id_use_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_use_rs2,
   input  logic [CTRL_W-1:0] id_ctrl,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_wen,
   output logic              stall,
   output logic              pc_we,
   output logic              ifid_we,
   output logic [CTRL_W-1:0] idex_ctrl
);
   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("raw_interlock: REG_AW must lie in 1..8");
      end
      if (CTRL_W < 1) begin : g_bad_cw
         $error("raw_interlock: CTRL_W must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0][REG_AW-1:0] src_num;
   logic [NUM_SRC-1:0]             src_used;
   logic [NUM_STG-1:0][REG_AW-1:0] dst_num;
   logic [NUM_STG-1:0]             dst_wen;
   logic [NUM_STG-1:0][NUM_SRC-1:0] hit;

   always_comb begin
      src_num[0]       = id_rs1;
      src_num[1]       = id_rs2;
      src_used[0]      = id_use_rs1;
      src_used[1]      = id_use_rs2;
      dst_num[STG_EX]  = ex_rd;
      dst_num[STG_MEM] = mem_rd;
      dst_num[STG_WB]  = wb_rd;
      dst_wen[STG_EX]  = ex_wen;
      dst_wen[STG_MEM] = mem_wen;
      dst_wen[STG_WB]  = wb_wen;
   end

   generate
      for (genvar t = 0; t < NUM_STG; t++) begin : g_stg
         for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            ilk_cmp #(.AW(REG_AW)) u_cmp (
               .src      (src_num[s]),
               .src_used (src_used[s]),
               .dst      (dst_num[t]),
               .dst_wen  (dst_wen[t]),
               .hit      (hit[t][s])
            );
         end
      end
   endgenerate

   ilk_policy #(.WB_RF_BYPASS(WB_RF_BYPASS)) u_policy (
      .fwd_en     (fwd_en),
      .ex_is_load (ex_is_load),
      .hit        (hit),
      .stall      (stall)
   );

   ilk_bubble #(.CW(CTRL_W)) u_bubble (
      .stall    (stall),
      .ctrl_in  (id_ctrl),
      .ctrl_out (idex_ctrl),
      .pc_we    (pc_we),
      .ifid_we  (ifid_we)
   );
endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk #(
   parameter int REG_AW = 5,
   parameter int CTRL_W = 8
) (
   input logic              fwd_en,
   input logic [REG_AW-1:0] id_rs1,
   input logic              id_use_rs1,
   input logic [REG_AW-1:0] id_rs2,
   input logic              id_use_rs2,
   input logic [CTRL_W-1:0] id_ctrl,
   input logic [REG_AW-1:0] ex_rd,
   input logic              ex_wen,
   input logic              ex_is_load,
   input logic [REG_AW-1:0] mem_rd,
   input logic              mem_wen,
   input logic [REG_AW-1:0] wb_rd,
   input logic              wb_wen,
   input logic              stall,
   input logic              pc_we,
   input logic              ifid_we,
   input logic [CTRL_W-1:0] idex_ctrl
);
   always_comb begin
      // R1: execute-stage writer of a used first source forces a wait in full interlock
      a_r1_ex_dep: assert (!(!fwd_en && id_use_rs1 && ex_wen && ex_rd != '0 &&
                              ex_rd == id_rs1) || stall);
      // R4: all destinations zero -> nothing can depend
      a_r4_zero_reg: assert (!(ex_rd == '0 && mem_rd == '0 && wb_rd == '0) || !stall);
      // R5: no writer anywhere -> no wait
      a_r5_no_wen: assert (ex_wen || mem_wen || wb_wen || !stall);
      // R6: no sources read -> no wait
      a_r6_no_use: assert (id_use_rs1 || id_use_rs2 || !stall);
      // R7: bypass mode waits only behind a load
      a_r7_load_only: assert (!(fwd_en && !ex_is_load) || !stall);
      // R8: both holds agree and oppose the stall flag
      a_r8_hold: assert ((pc_we == ifid_we) && (pc_we != stall));
      // R9: bubble zeroes control, otherwise it passes through
      a_r9_bubble: assert (stall ? (idex_ctrl == '0) : (idex_ctrl == id_ctrl));
   end
endmodule

bind raw_interlock raw_interlock_chk #(.REG_AW(REG_AW), .CTRL_W(CTRL_W)) u_chk (
   .fwd_en     (fwd_en),
   .id_rs1     (id_rs1),
   .id_use_rs1 (id_use_rs1),
   .id_rs2     (id_rs2),
   .id_use_rs2 (id_use_rs2),
   .id_ctrl    (id_ctrl),
   .ex_rd      (ex_rd),
   .ex_wen     (ex_wen),
   .ex_is_load (ex_is_load),
   .mem_rd     (mem_rd),
   .mem_wen    (mem_wen),
   .wb_rd      (wb_rd),
   .wb_wen     (wb_wen),
   .stall      (stall),
   .pc_we      (pc_we),
   .ifid_we    (ifid_we),
   .idex_ctrl  (idex_ctrl)
);

// File: tb/raw_interlock_bench.sv
`timescale 1ns/1ps
module raw_interlock_bench;
   localparam int AW = 5;
   localparam int CW = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          fwd_en, use1, use2, ex_wen, ex_ld, mem_wen, wb_wen;
   logic [AW-1:0] rs1, rs2, ex_rd, mem_rd, wb_rd;
   logic [CW-1:0] ctrl;
   logic          st_a, pcw_a, ifw_a, st_b, pcw_b, ifw_b;
   logic [CW-1:0] oc_a, oc_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   raw_interlock #(.REG_AW(AW), .CTRL_W(CW), .WB_RF_BYPASS(1'b0)) u_raw_interlock (
      .fwd_en(fwd_en), .id_rs1(rs1), .id_use_rs1(use1), .id_rs2(rs2), .id_use_rs2(use2),
      .id_ctrl(ctrl), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_ld),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .stall(st_a), .pc_we(pcw_a), .ifid_we(ifw_a), .idex_ctrl(oc_a));

   raw_interlock #(.REG_AW(AW), .CTRL_W(CW), .WB_RF_BYPASS(1'b1)) u_raw_interlock_wbm (
      .fwd_en(fwd_en), .id_rs1(rs1), .id_use_rs1(use1), .id_rs2(rs2), .id_use_rs2(use2),
      .id_ctrl(ctrl), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_ld),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .stall(st_b), .pc_we(pcw_b), .ifid_we(ifw_b), .idex_ctrl(oc_b));

   function automatic bit dep(bit u, logic [AW-1:0] s, logic [AW-1:0] d, bit w);
      return u && w && (d != 0) && (d == s);
   endfunction

   function automatic bit exp_stall(bit mask_wb);
      bit e, m, b;
      e = dep(use1, rs1, ex_rd, ex_wen)  || dep(use2, rs2, ex_rd, ex_wen);
      m = dep(use1, rs1, mem_rd, mem_wen) || dep(use2, rs2, mem_rd, mem_wen);
      b = dep(use1, rs1, wb_rd, wb_wen)  || dep(use2, rs2, wb_rd, wb_wen);
      if (fwd_en) return e && ex_ld;
      return e || m || (b && !mask_wb);
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle();
      fwd_en = 0; use1 = 0; use2 = 0; rs1 = 0; rs2 = 0; ctrl = 8'h5A;
      ex_rd = 0; ex_wen = 0; ex_ld = 0; mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0;
   endtask

   task automatic settle();
      #2;
   endtask

   // full bundle {stall, pc_we, ifid_we, ctrl} expected for one instance
   function automatic logic [31:0] bundle(bit s);
      return {21'd0, s, ~s, ~s, (s ? 8'h00 : ctrl)};
   endfunction

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      idle();
      @(negedge clk);
      check("R8 idle pc_we", {31'd0, pcw_a}, 32'd1);
      check("R9 idle ctrl pass", {24'd0, oc_a}, {24'd0, 8'h5A});

      // R1: execute-stage dependence on rs1
      idle(); use1 = 1; rs1 = 7; ex_rd = 7; ex_wen = 1; settle();
      check("R1 ex dep", {31'd0, st_a}, 32'd1);
      check("R8 stall holds", {30'd0, pcw_a, ifw_a}, 32'd0);
      check("R9 bubble zero", {24'd0, oc_a}, 32'd0);
      // R2: memory-stage dependence
      idle(); use1 = 1; rs1 = 31; mem_rd = 31; mem_wen = 1; settle();
      check("R2 mem dep", {31'd0, st_a}, 32'd1);
      // R3: writeback-stage dependence, live vs masked
      idle(); use2 = 1; rs2 = 12; wb_rd = 12; wb_wen = 1; settle();
      check("R3 wb live", {31'd0, st_a}, 32'd1);
      check("R3 wb masked", {31'd0, st_b}, 32'd0);
      // R4: register zero
      idle(); use1 = 1; use2 = 1; ex_wen = 1; mem_wen = 1; wb_wen = 1; ex_ld = 1; settle();
      check("R4 zero reg", {30'd0, st_a, st_b}, 32'd0);
      // R5: write enable clear
      idle(); use1 = 1; rs1 = 3; ex_rd = 3; mem_rd = 3; wb_rd = 3; settle();
      check("R5 no wen", {31'd0, st_a}, 32'd0);
      // R6: unused source
      idle(); rs1 = 4; rs2 = 4; ex_rd = 4; ex_wen = 1; settle();
      check("R6 unused src", {31'd0, st_a}, 32'd0);
      // R7: bypass mode
      idle(); fwd_en = 1; use1 = 1; rs1 = 9; ex_rd = 9; ex_wen = 1; settle();
      check("R7 non-load ex ignored", {31'd0, st_a}, 32'd0);
      ex_ld = 1; settle();
      check("R7 load-use stalls", {31'd0, st_a}, 32'd1);
      idle(); fwd_en = 1; ex_ld = 1; use1 = 1; rs1 = 9; mem_rd = 9; mem_wen = 1;
      wb_rd = 9; wb_wen = 1; settle();
      check("R7 later stages ignored", {31'd0, st_a}, 32'd0);
      // R10: second source as address base
      idle(); use2 = 1; rs2 = 20; rs1 = 21; use1 = 1; ex_rd = 20; ex_wen = 1; settle();
      check("R10 rs2 base dep", {31'd0, st_a}, 32'd1);

      // R10 sweep: every combination over register numbers 0..2
      for (int f = 0; f < 2; f++)
      for (int u = 0; u < 4; u++)
      for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
      for (int e = 0; e < 3; e++)
      for (int ef = 0; ef < 4; ef++)
      for (int m = 0; m < 3; m++)
      for (int mw = 0; mw < 2; mw++)
      for (int w = 0; w < 3; w++)
      for (int ww = 0; ww < 2; ww++) begin
         fwd_en = f[0]; use1 = u[0]; use2 = u[1];
         rs1 = AW'(a); rs2 = AW'(b);
         ex_rd = AW'(e); ex_wen = ef[0]; ex_ld = ef[1];
         mem_rd = AW'(m); mem_wen = mw[0]; wb_rd = AW'(w); wb_wen = ww[0];
         ctrl = 8'(a * 37 + e * 11 + m * 5 + w + 1);
         #2;
         check("R10 sweep live", {21'd0, st_a, pcw_a, ifw_a, oc_a}, bundle(exp_stall(1'b0)));
         check("R10 sweep masked", {21'd0, st_b, pcw_b, ifw_b, oc_b}, bundle(exp_stall(1'b1)));
         #2;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule